// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block drives one DMA channel. Software loads a source address, a fixed destination address and a transfer count through a small word-wide register port. It then sets a control word that picks byte or word size, how the source address moves, and whether transfers start on their own or wait for an external pulse. While the channel runs, each transfer appears as one request on a valid/ready memory port that carries the source, the destination and the size.

The channel runs only while both its own enable and a master enable are set. Software cannot set the channel enable with a plain write. It must first read the control word while the enable is 0, and only then write a 1. When the count runs out, the hardware clears the enable. If interrupts are enabled, an interrupt level is then raised and held until software acknowledges it.

Top module: `dma_chan_seq`

## Requirements
- R1: Transfers are issued only while channel enable (control bit 0) and master enable (control bit 8) are both 1; with master at 0, `mem_valid` stays low and the count is unchanged.
- R2: With auto mode (control bit 5) set, `mem_valid` rises on the second clock edge after the enabling write, with no external request.
- R3: With auto mode clear, each `xfer_req` pulse yields exactly one transfer; pulses that arrive while the channel enable is 0 are dropped and cause no later transfer.
- R4: The 16-bit count (register offset 2) decrements on every completed handshake; the handshake that finds a count of 1 clears the channel enable, and a loaded count of 0 wraps to 0xFFFF after one transfer and keeps the channel running (65536 transfers).
- R5: A write of 1 to control bit 0 sets the channel enable only if the control word (offset 0) was read while the enable was 0, with no control write in between; otherwise the enable stays 0.
- R6: When interrupt enable (control bit 1) is 1, `irq` goes high in the same edge that clears the channel enable, and it stays high until a control write with bit 0 = 1 or with bit 1 = 0.
- R7: After reset the control word reads 0 and `mem_valid` and `irq` are 0; `mem_wide` shows the size bit (control bit 2: 0 byte, 1 word) for each request.
- R8: Source mode: with control bit 4 = 0 the source address (offset 1) is held. With bit 4 = 1, control bit 3 = 0 steps it up and bit 3 = 1 steps it down, by 1 for bytes and 2 for words.
- R9: `mem_valid` stays high with a stable `mem_src` until `mem_ready`. The address step and count decrement take effect on the edge where both are high, and `mem_valid` drops on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 source, 2 count, 3 destination |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| xfer_req | input | 1 | External transfer request pulse |
| mem_valid | output | 1 | Transfer request to memory side |
| mem_ready | input | 1 | Memory side accepts the request |
| mem_src | output | 16 | Source address of the current request |
| mem_dst | output | 16 | Destination address (fixed) |
| mem_wide | output | 1 | 1 for a word transfer, 0 for a byte |
| irq | output | 1 | Completion interrupt level |

## Verification
A register write takes effect on the edge where it is strobed, and the read data is ready one edge after the read strobe. `mem_valid` rises one edge after the channel becomes active. Address, count, enable and interrupt all update on the edge that completes a handshake. The bench drives and samples only on falling edges, so every check falls half a cycle after the edge that should have produced its value. The memory responder logs a handshake at the falling edge before the rising edge that completes it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_IE     = 1;
  localparam int unsigned BIT_WIDE   = 2;
  localparam int unsigned BIT_DIR    = 3;
  localparam int unsigned BIT_STEP   = 4;
  localparam int unsigned BIT_AUTO   = 5;
  localparam int unsigned BIT_MASTER = 8;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_SRC  = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;
  localparam logic [1:0] RA_DST  = 2'd3;

  typedef struct packed {
    logic master;
    logic auto_go;
    logic step_en;
    logic dir;
    logic wide;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              step_en,
  input  logic              dir,
  input  logic              wide,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] STRIDE_B = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STRIDE_W = ADDR_W'(2);

  logic [ADDR_W-1:0] stride;

  always_comb begin
    stride = wide ? STRIDE_W : STRIDE_B;
    if (!step_en)  nxt = cur;
    else if (dir)  nxt = cur - stride;
    else           nxt = cur + stride;
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_seq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              done,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] dst_q,
  output ctrl_t             cfg,
  output logic              chan_en,
  output logic              irq,
  output logic              src_wr,
  output logic              cnt_wr,
  output logic              dst_wr
);
  ctrl_t cfg_q, cfg_d;
  logic  en_q, en_d, arm_q, arm_d, irq_q, irq_d;
  logic  ctrl_wr;
  logic [REG_W-1:0] ctrl_view, rd_d, rd_q;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign src_wr  = reg_wr && (reg_addr == RA_SRC);
  assign cnt_wr  = reg_wr && (reg_addr == RA_CNT);
  assign dst_wr  = reg_wr && (reg_addr == RA_DST);

  always_comb begin
    cfg_d = cfg_q;
    en_d  = en_q;
    arm_d = arm_q;
    if (ctrl_wr) begin
      cfg_d.master  = reg_wdata[BIT_MASTER];
      cfg_d.auto_go = reg_wdata[BIT_AUTO];
      cfg_d.step_en = reg_wdata[BIT_STEP];
      cfg_d.dir     = reg_wdata[BIT_DIR];
      cfg_d.wide    = reg_wdata[BIT_WIDE];
      cfg_d.irq_en  = reg_wdata[BIT_IE];
      en_d          = reg_wdata[BIT_EN] & (en_q | arm_q);
      arm_d         = 1'b0;
    end else begin
      if (done) en_d = 1'b0;
      if (reg_rd && (reg_addr == RA_CTRL) && !en_q) arm_d = 1'b1;
    end
    irq_d = cfg_d.irq_en &
            ((irq_q & ~(ctrl_wr & reg_wdata[BIT_EN])) | (en_q & ~en_d));
  end

  always_comb begin
    ctrl_view             = '0;
    ctrl_view[BIT_EN]     = en_q;
    ctrl_view[BIT_IE]     = cfg_q.irq_en;
    ctrl_view[BIT_WIDE]   = cfg_q.wide;
    ctrl_view[BIT_DIR]    = cfg_q.dir;
    ctrl_view[BIT_STEP]   = cfg_q.step_en;
    ctrl_view[BIT_AUTO]   = cfg_q.auto_go;
    ctrl_view[BIT_MASTER] = cfg_q.master;
    case (reg_addr)
      RA_CTRL: rd_d = ctrl_view;
      RA_SRC:  rd_d = REG_W'(src_q);
      RA_CNT:  rd_d = REG_W'(cnt_q);
      default: rd_d = REG_W'(dst_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
      arm_q <= 1'b0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
      arm_q <= arm_d;
      irq_q <= irq_d;
      if (reg_rd) rd_q <= rd_d;
    end
  end

  assign cfg       = cfg_q;
  assign chan_en   = en_q;
  assign irq       = irq_q;
  assign reg_rdata = rd_q;

  // R4: completion removes the channel enable
  p_done_clears_en_r4: assert property (@(posedge clk) disable iff (rst)
    done && !ctrl_wr |=> !en_q);
  // R5: an unarmed write of 1 cannot enable the channel
  p_unarmed_write_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !arm_q && !en_q |=> !en_q);
  // R6: interrupt appears together with the enable falling
  p_irq_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(en_q) && !en_q);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             cfg,
  input  logic              chan_en,
  input  logic              req_in,
  input  logic              src_wr,
  input  logic              cnt_wr,
  input  logic              dst_wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic              mem_wide,
  output logic              done,
  output logic [ADDR_W-1:0] src_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] dst_q
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              valid_q, wide_q, pend_q, pend_d;
  logic              active, issue, hs;
  logic [ADDR_W-1:0] src_nxt;

  assign active = chan_en & cfg.master;
  assign issue  = active & ~valid_q & (cfg.auto_go | pend_q);
  assign hs     = valid_q & mem_ready;
  assign done   = hs & (cnt_q == CNT_ONE);
  assign pend_d = chan_en & ((pend_q & ~issue) | req_in);

  dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur     (src_q),
    .step_en (cfg.step_en),
    .dir     (cfg.dir),
    .wide    (cfg.wide),
    .nxt     (src_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      wide_q  <= 1'b0;
      pend_q  <= 1'b0;
      src_q   <= '0;
      cnt_q   <= '0;
      dst_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (issue) begin
        valid_q <= 1'b1;
        wide_q  <= cfg.wide;
      end else if (hs) begin
        valid_q <= 1'b0;
      end
      if (src_wr)  src_q <= wr_addr;
      else if (hs) src_q <= src_nxt;
      if (cnt_wr)  cnt_q <= wr_cnt;
      else if (hs) cnt_q <= cnt_q - CNT_ONE;
      if (dst_wr)  dst_q <= wr_addr;
    end
  end

  assign mem_valid = valid_q;
  assign mem_wide  = wide_q;

  // R9: request held with stable address until accepted
  p_hold_until_ready_r9: assert property (@(posedge clk) disable iff (rst)
    valid_q && !mem_ready && !src_wr |=> valid_q && $stable(src_q));
  // R1: a request only starts from an active channel
  p_start_needs_active_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(chan_en && cfg.master));
  // R4: each handshake takes one from the count
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    hs && !cnt_wr |=> cnt_q == $past(cnt_q) - CNT_ONE);
  // R3: requests cannot be held while the channel is off
  p_no_pending_off_r3: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !pend_q);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              xfer_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_src,
  output logic [ADDR_W-1:0] mem_dst,
  output logic              mem_wide,
  output logic              irq
);
  ctrl_t             cfg;
  logic              chan_en, done, src_wr, cnt_wr, dst_wr;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;

  dma_ctrl_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .done      (done),
    .src_q     (src_q),
    .cnt_q     (cnt_q),
    .dst_q     (dst_q),
    .cfg       (cfg),
    .chan_en   (chan_en),
    .irq       (irq),
    .src_wr    (src_wr),
    .cnt_wr    (cnt_wr),
    .dst_wr    (dst_wr)
  );

  dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .chan_en   (chan_en),
    .req_in    (xfer_req),
    .src_wr    (src_wr),
    .cnt_wr    (cnt_wr),
    .dst_wr    (dst_wr),
    .wr_addr   (reg_wdata[ADDR_W-1:0]),
    .wr_cnt    (reg_wdata[CNT_W-1:0]),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_wide  (mem_wide),
    .done      (done),
    .src_q     (src_q),
    .cnt_q     (cnt_q),
    .dst_q     (dst_q)
  );

  assign mem_src = src_q;
  assign mem_dst = dst_q;
endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  localparam int EN = 1, IE = 2, WIDE = 4, DIR = 8, STEP = 16, AUTO = 32, MST = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, xfer_req = 0, mem_ready = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata, mem_src, mem_dst;
  logic mem_valid, mem_wide, irq;

  int total = 0, bad = 0, hs_cnt = 0;
  logic [15:0] log_addr [16];
  logic        log_wide [16];
  logic        finished = 0;

  always #4 clk = ~clk;

  dma_chan_seq dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_src(mem_src),
    .mem_dst(mem_dst), .mem_wide(mem_wide), .irq(irq)
  );

  always @(negedge clk) begin
    if (mem_valid && mem_ready) begin
      if (hs_cnt < 16) begin
        log_addr[hs_cnt] = mem_src;
        log_wide[hs_cnt] = mem_wide;
      end
      hs_cnt = hs_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = 16'(d);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1;
    @(negedge clk); xfer_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_enable(input int ctrl);
    logic [15:0] d;
    rd(0, d);
    wr(0, ctrl | EN);
  endtask

  task automatic setup(input int src, input int cnt);
    wr(1, src); wr(2, cnt); hs_cnt = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(0, d);
    chk("R7", "ctrl after reset", d, 0);
    chk("R7", "mem_valid after reset", mem_valid, 0);
    chk("R7", "irq after reset", irq, 0);
  endtask

  task automatic t_unarmed();
    logic [15:0] d;
    mem_ready = 1;
    setup(16'h0010, 2);
    wr(0, MST | AUTO);
    wr(0, MST | AUTO | EN);
    idle(4);
    rd(0, d);
    chk("R5", "enable after unarmed write", d[0], 0);
    chk("R5", "no transfers unarmed", hs_cnt, 0);
    wr(0, MST | AUTO | EN);
    idle(6);
    chk("R5", "armed write runs channel", hs_cnt, 2);
    wr(0, 0);
  endtask

  task automatic t_master();
    logic [15:0] d;
    mem_ready = 1;
    setup(16'h0600, 2);
    wr(0, AUTO | STEP);
    arm_enable(AUTO | STEP);
    idle(6);
    chk("R1", "no request without master", hs_cnt, 0);
    rd(2, d);
    chk("R1", "count held without master", d, 2);
    wr(0, AUTO | STEP | MST | EN);
    idle(8);
    chk("R1", "transfers once master set", hs_cnt, 2);
  endtask

  task automatic t_auto_inc_byte();
    logic [15:0] d;
    mem_ready = 1;
    setup(16'h0100, 3);
    arm_enable(MST | AUTO | STEP);
    chk("R2", "valid not yet after enable edge", mem_valid, 0);
    @(negedge clk);
    chk("R2", "valid one edge after enable", mem_valid, 1);
    idle(12);
    chk("R4", "three transfers", hs_cnt, 3);
    chk("R8", "inc byte addr0", log_addr[0], 16'h0100);
    chk("R8", "inc byte addr1", log_addr[1], 16'h0101);
    chk("R8", "inc byte addr2", log_addr[2], 16'h0102);
    chk("R7", "byte size flag", log_wide[0], 0);
    rd(0, d);
    chk("R4", "enable cleared at end", d[0], 0);
    rd(1, d);
    chk("R8", "final source", d, 16'h0103);
    rd(2, d);
    chk("R4", "final count", d, 0);
    chk("R6", "no irq when disabled", irq, 0);
  endtask

  task automatic t_dec_word();
    mem_ready = 1;
    setup(16'h0200, 2);
    arm_enable(MST | AUTO | STEP | DIR | WIDE);
    idle(10);
    chk("R8", "dec word count", hs_cnt, 2);
    chk("R8", "dec word addr0", log_addr[0], 16'h0200);
    chk("R8", "dec word addr1", log_addr[1], 16'h01FE);
    chk("R7", "word size flag", log_wide[1], 1);
  endtask

  task automatic t_fixed();
    mem_ready = 1;
    setup(16'h0300, 2);
    arm_enable(MST | AUTO | WIDE | DIR);
    idle(10);
    chk("R8", "fixed addr0", log_addr[0], 16'h0300);
    chk("R8", "fixed addr1", log_addr[1], 16'h0300);
  endtask

  task automatic t_request();
    logic [15:0] d;
    mem_ready = 1;
    setup(16'h0400, 3);
    wr(0, MST | STEP);
    pulse_req();
    idle(3);
    arm_enable(MST | STEP);
    idle(6);
    chk("R3", "request while off dropped", hs_cnt, 0);
    pulse_req();
    idle(4);
    chk("R3", "one pulse one transfer", hs_cnt, 1);
    pulse_req();
    idle(4);
    chk("R3", "second pulse", hs_cnt, 2);
    rd(2, d);
    chk("R3", "count after two", d, 1);
    chk("R3", "second address", log_addr[1], 16'h0401);
    wr(0, 0);
  endtask

  task automatic t_stall();
    logic [15:0] d;
    mem_ready = 0;
    setup(16'h0500, 2);
    arm_enable(MST | AUTO | STEP);
    idle(4);
    chk("R9", "valid held while stalled", mem_valid, 1);
    chk("R9", "source stable while stalled", mem_src, 16'h0500);
    rd(2, d);
    chk("R9", "count held while stalled", d, 2);
    mem_ready = 1;
    idle(8);
    chk("R9", "transfers after ready", hs_cnt, 2);
    chk("R9", "addr after stall", log_addr[1], 16'h0501);
  endtask

  task automatic t_irq();
    mem_ready = 1;
    setup(16'h0700, 1);
    arm_enable(MST | AUTO | IE);
    idle(6);
    chk("R6", "irq on completion", irq, 1);
    idle(5);
    chk("R6", "irq is a level", irq, 1);
    wr(0, MST | IE);
    chk("R6", "irq kept on write of 0", irq, 1);
    wr(0, MST | IE | EN);
    chk("R6", "irq cleared by enable write", irq, 0);
    idle(4);
    chk("R5", "unarmed write did not restart", hs_cnt, 1);
    setup(16'h0700, 1);
    arm_enable(MST | AUTO | IE);
    idle(6);
    chk("R6", "irq raised again", irq, 1);
    wr(0, MST);
    chk("R6", "irq cleared by ie=0", irq, 0);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    mem_ready = 1;
    setup(16'h0800, 0);
    arm_enable(MST | STEP);
    pulse_req();
    idle(4);
    rd(2, d);
    chk("R4", "zero count wraps", d, 16'hFFFF);
    rd(0, d);
    chk("R4", "still enabled after wrap", d[0], 1);
    wr(0, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_unarmed();
    t_master();
    t_auto_inc_byte();
    t_dec_word();
    t_fixed();
    t_request();
    t_stall();
    t_irq();
    t_wrap();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule